// File: doc/BRIEF.md
# Serial Display Register Write Controller

This block turns single register updates from a host into the three-wire serial traffic expected by an eight-digit seven-segment and bicolour-LED display controller. The three wires are a strobe, a bus clock and a data line that only carries data out of the block. The host offers one request at a time on a valid/ready handshake. A request is either a register write, made of a 4-bit address and an 8-bit value, or a display control setting, made of an enable bit and a 3-bit brightness. The block serialises the command frames that the request calls for. It derives the bus clock from the fast system clock by counting.

In the display's register space, even addresses hold the pattern for one digit. Bit 0 of that pattern is the top segment and bit 7 is the centre or point segment. Odd addresses hold one LED, where bit 0 lights it red and bit 1 lights it green. The block passes the value through unchanged, so this mapping belongs to the host. When reset is released, the block switches the display on at a medium brightness and only then opens its handshake.

Top module: `segLedBusWriter`

## Requirements
- R1: During reset and whenever no frame is in progress, busStb, busClk and busDat are all 1. reqReady is 0 during reset.
- R2: After reset is released, the block sends exactly one single-byte frame 0x8C (display on, brightness 4). reqReady first rises only after that frame's strobe has returned high.
- R3: A write request (reqIsCtrl=0) produces two frames. The first is a single-byte frame 0x44. The second is a two-byte frame under one strobe low period, holding first 0xC0 | reqAddr and then reqData.
- R4: A control request (reqIsCtrl=1) produces one single-byte frame 0x80 | reqData[3:0]. Here reqData[3] is the display enable and reqData[2:0] is the brightness. reqAddr and reqData[7:4] have no effect.
- R5: Each byte is sent least significant bit first. For each bit, busClk falls, busDat takes the bit in that same cycle, and busClk then rises; the receiver samples busDat on that rising edge. busDat does not change while busClk is high and busStb is low, and busClk is low only while busStb is low.
- R6: Every bus line change lands on a divider tick, one tick every HALF_DIV system clocks. Each low phase of busClk therefore lasts exactly HALF_DIV system clocks.
- R7: A request is accepted on a clock where reqValid and reqReady are both 1. From the next clock, reqReady stays 0 until the last frame of that request has ended. A request held valid while the block is busy is served later and is not dropped.
- R8: busStb stays high for at least 2*HALF_DIV system clocks before every falling edge.
- R9: A synchronous reset asserted in the middle of a frame returns all three bus lines to 1 on the next clock and abandons the request. The block then repeats the power-up sequence of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can accept a request |
| reqIsCtrl | input | 1 | 1 = display control request, 0 = register write |
| reqAddr | input | 4 | Register address for a write |
| reqData | input | 8 | Write value, or {unused[7:4], enable, brightness[2:0]} |
| busStb | output | 1 | Frame strobe, active low |
| busClk | output | 1 | Serial bus clock |
| busDat | output | 1 | Serial data, LSB first |

## Verification
A bad bit counter or byte index in the sequencer shows up at the ports as a frame with the wrong byte count, or as a byte split across two strobe periods. The scoreboard catches this when that frame's strobe rises, one frame after the fault at the latest. A divider or pacing fault shows up as a bus clock low phase of the wrong length, or as a strobe gap that is too short, on the first bit or frame boundary after the fault. A handshake fault either leaves an expected frame missing when the run drains, or brings reqReady back while strobe activity continues. The end-of-run queue check and the check made just after each acceptance detect these.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int SEQ_MAX = 4;
  localparam int IDX_W = $clog2(SEQ_MAX);
  localparam int BIT_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] MODE_FIXED = 8'h44;
  localparam logic [BYTE_W-1:0] WRITE_BASE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_BASE  = 8'h80;
  localparam logic [BYTE_W-1:0] INIT_CTRL  = 8'h8C;

  typedef struct packed {
    logic              start;
    logic              bitLo;
    logic              bitHi;
    logic              stop;
    logic              load;
    logic [BYTE_W-1:0] loadByte;
  } busCmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BITLO, S_BITHI, S_STOP, S_GAP
  } seqState_t;
endpackage

// File: rtl/segbus_datapath.sv
module segbus_datapath
  import segbus_pkg::*;
#(
  parameter int HALF_DIV = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  busCmd_t cmd,
  output logic    tick,
  output logic    busStb,
  output logic    busClk,
  output logic    busDat
);
  localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] shiftReg;

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)       divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      busStb   <= 1'b1;
      busClk   <= 1'b1;
      busDat   <= 1'b1;
    end else begin
      if (cmd.start) busStb <= 1'b0;
      if (cmd.bitLo) begin
        busClk <= 1'b0;
        busDat <= shiftReg[0];
      end
      if (cmd.bitHi) busClk <= 1'b1;
      if (cmd.load)       shiftReg <= cmd.loadByte;
      else if (cmd.bitHi) shiftReg <= {1'b0, shiftReg[BYTE_W-1:1]};
      if (cmd.stop) begin
        busStb <= 1'b1;
        busClk <= 1'b1;
        busDat <= 1'b1;
      end
    end
  end

  assert_div_range_R6: assert property (@(posedge clk) disable iff (rst)
    divCnt <= DIV_LAST);

  assert_lines_paced_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({busStb, busClk, busDat}));

  assert_clk_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    !busClk |-> !busStb);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!busStb && $past(!busStb) && !$stable(busDat)) |-> !busClk);
endmodule

// File: rtl/segbus_ctrl.sv
module segbus_ctrl
  import segbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              reqValid,
  input  logic              reqIsCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqData,
  output logic              reqReady,
  output busCmd_t           cmd
);
  seqState_t                          state;
  logic [SEQ_MAX-1:0][BYTE_W-1:0]     seqByte;
  logic [SEQ_MAX-1:0]                 seqEnd;
  logic [IDX_W-1:0]                   seqLen;
  logic [IDX_W-1:0]                   idx;
  logic [BIT_W-1:0]                   bitCnt;
  logic                               gapCnt;
  logic                               lastBit;

  assign reqReady = (state == S_IDLE);
  assign lastBit  = (bitCnt == BIT_W'(BYTE_W - 1));

  always_comb begin
    cmd = '0;
    if (tick) begin
      unique case (state)
        S_START: begin
          cmd.start    = 1'b1;
          cmd.load     = 1'b1;
          cmd.loadByte = seqByte[idx];
        end
        S_BITLO: cmd.bitLo = 1'b1;
        S_BITHI: begin
          cmd.bitHi = 1'b1;
          if (lastBit && !seqEnd[idx]) begin
            cmd.load     = 1'b1;
            cmd.loadByte = seqByte[idx + 1'b1];
          end
        end
        S_STOP:  cmd.stop = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_GAP;
      seqByte <= '0;
      seqByte[0] <= INIT_CTRL;
      seqEnd  <= SEQ_MAX'(1);
      seqLen  <= IDX_W'(1);
      idx     <= '0;
      bitCnt  <= '0;
      gapCnt  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          idx   <= '0;
          state <= S_START;
          if (reqIsCtrl) begin
            seqByte[0] <= CTRL_BASE | {4'b0, reqData[3:0]};
            seqEnd     <= SEQ_MAX'(1);
            seqLen     <= IDX_W'(1);
          end else begin
            seqByte[0] <= MODE_FIXED;
            seqByte[1] <= WRITE_BASE | {{(BYTE_W-ADDR_W){1'b0}}, reqAddr};
            seqByte[2] <= reqData;
            seqEnd     <= SEQ_MAX'(5);
            seqLen     <= IDX_W'(3);
          end
        end
        S_START: if (tick) begin
          bitCnt <= '0;
          state  <= S_BITLO;
        end
        S_BITLO: if (tick) state <= S_BITHI;
        S_BITHI: if (tick) begin
          if (lastBit) begin
            if (seqEnd[idx]) begin
              state <= S_STOP;
            end else begin
              idx    <= idx + 1'b1;
              bitCnt <= '0;
              state  <= S_BITLO;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= S_BITLO;
          end
        end
        S_STOP: if (tick) begin
          idx    <= idx + 1'b1;
          gapCnt <= 1'b0;
          state  <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gapCnt) begin
            if (idx == seqLen) begin
              idx   <= '0;
              state <= S_IDLE;
            end else begin
              state <= S_START;
            end
          end else begin
            gapCnt <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (idx <= seqLen));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (!reqReady && !cmd.stop));
endmodule

// File: rtl/segLedBusWriter.sv
module segLedBusWriter
  import segbus_pkg::*;
#(
  parameter int HALF_DIV = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqIsCtrl,
  input  logic [3:0]  reqAddr,
  input  logic [7:0]  reqData,
  output logic        busStb,
  output logic        busClk,
  output logic        busDat
);
  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_MIN + 1) + 1;

  busCmd_t cmd;
  logic    tick;

  segbus_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick(tick),
    .reqValid(reqValid), .reqIsCtrl(reqIsCtrl),
    .reqAddr(reqAddr), .reqData(reqData),
    .reqReady(reqReady), .cmd(cmd)
  );

  segbus_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .tick(tick),
    .busStb(busStb), .busClk(busClk), .busDat(busDat)
  );

  logic [GAP_W-1:0] stbHighCnt;
  always_ff @(posedge clk) begin
    if (rst || !busStb) stbHighCnt <= '0;
    else if (stbHighCnt < GAP_W'(GAP_MIN)) stbHighCnt <= stbHighCnt + 1'b1;
  end

  assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busStb) |-> (stbHighCnt >= GAP_W'(GAP_MIN)));

  assert_busy_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busStb) |-> !reqReady);
endmodule

// File: tb/tb_segLedBusWriter.sv
module tb_segLedBusWriter;
  localparam int HD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqIsCtrl = 1'b0;
  logic [3:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic reqReady, busStb, busClk, busDat;

  int checks = 0, errors = 0, framesSeen = 0;
  bit finished = 0;
  logic [31:0] expQ[$];

  always #2.5 clk = ~clk;

  segLedBusWriter #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsCtrl(reqIsCtrl), .reqAddr(reqAddr), .reqData(reqData),
    .busStb(busStb), .busClk(busClk), .busDat(busDat)
  );

  function automatic logic [31:0] mk(int n, logic [7:0] b0, logic [7:0] b1);
    return {8'(n), 8'h00, b1, b0};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: decodes frames at the bus pins and scores them
  logic pS = 1, pC = 1, pD = 1, inFrame = 0;
  int nBits = 0, nBytes = 0, lowCnt = 0, highCnt = 0;
  logic [7:0] cur, fb0, fb1;
  always @(negedge clk) begin
    if (rst) begin
      inFrame = 0; pS = 1; pC = 1; pD = 1; highCnt = 0;
    end else begin
      if (pS && !busStb) begin
        check(highCnt >= 2*HD, "R8 strobe gap", highCnt, 2*HD);
        inFrame = 1; nBits = 0; nBytes = 0; fb0 = 0; fb1 = 0;
      end
      if (busStb) highCnt++; else highCnt = 0;
      if (!busClk) lowCnt++;
      if (inFrame && !pC && busClk) begin
        check(lowCnt == HD, "R6 clock low width", lowCnt, HD);
        cur[nBits % 8] = busDat;
        nBits++;
        if (nBits % 8 == 0) begin
          if (nBytes == 0) fb0 = cur; else fb1 = cur;
          nBytes++;
        end
      end
      if (pC && !busClk) lowCnt = 1;
      if (!busStb && !pS && busClk && pC && busDat !== pD)
        check(0, "R5 data moved while clock high", busDat, pD);
      if (inFrame && busStb && !pS) begin
        inFrame = 0;
        framesSeen++;
        if (expQ.size() == 0)
          check(0, "R3 unexpected frame", mk(nBytes, fb0, fb1), 0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(nBits % 8 == 0 && mk(nBytes, fb0, fb1) == e,
                "R3/R4/R5 frame content", mk(nBytes, fb0, fb1), e);
        end
      end
      pS = busStb; pC = busClk; pD = busDat;
    end
  end

  task automatic doReq(bit isCtrl, logic [3:0] a, logic [7:0] d);
    if (isCtrl) expQ.push_back(mk(1, 8'h80 | {4'h0, d[3:0]}, 8'h00));
    else begin
      expQ.push_back(mk(1, 8'h44, 8'h00));
      expQ.push_back(mk(2, 8'hC0 | {4'h0, a}, d));
    end
    @(negedge clk);
    reqValid = 1; reqIsCtrl = isCtrl; reqAddr = a; reqData = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0; reqAddr = $urandom; reqData = $urandom;
    check(reqReady == 0, "R7 ready low after accept", reqReady, 0);
  endtask

  task automatic drain();
    while (expQ.size() != 0 || !reqReady) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busStb, busClk, busDat} == 3'b111, "R1 lines high in reset",
          {busStb, busClk, busDat}, 3'b111);
    check(reqReady == 0, "R1 ready low in reset", reqReady, 0);
    expQ.push_back(mk(1, 8'h8C, 8'h00));
    rst = 0;
    while (!reqReady) @(negedge clk);
    check(framesSeen == 1, "R2 init frame before ready", framesSeen, 1);
    check({busStb, busClk, busDat} == 3'b111, "R1 idle lines high",
          {busStb, busClk, busDat}, 3'b111);

    doReq(0, 4'h0, 8'h01);
    doReq(0, 4'h5, 8'h02);
    doReq(0, 4'hF, 8'hA5);
    doReq(0, 4'hE, 8'h80);
    doReq(1, 4'h3, 8'h0F);
    doReq(1, 4'h0, 8'h00);
    doReq(1, 4'hA, 8'hF3);
    drain();
    check({busStb, busClk, busDat} == 3'b111, "R1 idle after requests",
          {busStb, busClk, busDat}, 3'b111);

    // R9: reset in the middle of the first frame of a write
    doReq(0, 4'h2, 8'h3C);
    repeat (30) @(negedge clk);
    check(busStb == 0, "R9 frame in progress", busStb, 0);
    rst = 1;
    @(negedge clk);
    check({busStb, busClk, busDat} == 3'b111, "R9 lines high after reset",
          {busStb, busClk, busDat}, 3'b111);
    expQ.delete();
    expQ.push_back(mk(1, 8'h8C, 8'h00));
    framesSeen = 0;
    rst = 0;
    while (!reqReady) @(negedge clk);
    check(framesSeen == 1, "R9 init repeated", framesSeen, 1);

    doReq(0, 4'h7, 8'hC3);
    doReq(1, 4'h0, 8'h09);
    drain();
    check(expQ.size() == 0, "R7 no request dropped", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule